// File: doc/BRIEF.md
# DDR SDRAM Power-State Tracker

This block sits on the controller side of a DDR SDRAM interface and follows the memory device's power state. It watches the clock-enable line, the four command strobes and two plain hints from the rest of the controller. The first hint says a column access (read or write burst) is still in flight. The second says at least one bank is open. At every clock edge it combines three things: the clock-enable level registered at the previous edge, the level at the current edge, and the command decoded at the current edge. From these it moves between the running states, the two power-down flavours, self refresh and a post-self-refresh wait.

After self refresh ends, the device's delay-locked loop needs a fixed number of clocks to relock. The tracker counts these cycles and keeps its read-permitted output low until the count has run out. Any edge whose combination of levels, state and command is not an allowed transition raises a one-cycle illegal flag and leaves the state where it was. Every pin is a plain level signal. Nothing flows through the block, so there is no stream handshake and no back-pressure.

Top module: `ddr_pwr_tracker`

## Requirements
- R1: While `rst` is high and after it falls, `state_o` is 0 (idle), `illegal_o` is 0 and `read_ok_o` is 1, and the previous clock-enable level is taken as high.
- R2: Command encoding on (`cs_n`,`ras_n`,`cas_n`,`we_n`): deselect is `cs_n`=1; no-operation is 0,1,1,1; auto refresh is 0,0,0,1; read is 0,1,0,1; every other pattern is some other command. With clock enable high at both edges in the running states, any command is legal and `state_o` becomes 1 (active) when `bank_active` is 1 and 0 (idle) otherwise.
- R3: Clock enable going high-to-low in a running state, with deselect or no-operation and `col_busy` low, enters precharge power-down (`state_o`=2) when `bank_active` is 0 and active power-down (`state_o`=3) when it is 1.
- R4: Clock enable going high-to-low in a running state, with auto refresh, `bank_active` 0 and `col_busy` low, enters self refresh (`state_o`=4).
- R5: With clock enable low at both edges in state 2, 3 or 4, the state is held and the command strobes have no effect; `illegal_o` stays 0.
- R6: Clock enable going low-to-high with deselect or no-operation leaves power-down for state 1 or 0 (per `bank_active`), and leaves self refresh for the relock wait (`state_o`=5).
- R7: The relock wait lasts DLL_CYCLES edges after the exit edge. Counting the exit edge as edge 0, the state becomes 0 at edge DLL_CYCLES, provided no illegal combination occurs during the wait. `read_ok_o` is 1 only in states 0 and 1 with the wait finished, so it is 0 throughout the wait and in states 2 to 4.
- R8: During the relock wait, any command other than deselect or no-operation raises `illegal_o` and the state stays 5.
- R9: Clock enable dropping while `col_busy` is 1 is illegal: `illegal_o` rises and the state is unchanged.
- R10: Every other combination of levels, state and command is illegal and leaves the state unchanged. Examples are a wrong command on a low-to-high edge, auto refresh with a bank open, low-to-high in a running state, and high-to-low from a low-power state.
- R11: `illegal_o` is registered: it is 1 for exactly the cycle after an illegal edge and 0 after a legal one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock-enable level driven to the device |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| col_busy | input | 1 | A column access is still in flight |
| bank_active | input | 1 | At least one bank is open |
| state_o | output | 3 | Power state: 0 idle, 1 active, 2 precharge power-down, 3 active power-down, 4 self refresh, 5 relock wait |
| illegal_o | output | 1 | Previous edge carried a forbidden combination |
| read_ok_o | output | 1 | A read may be issued at the next edge |

## Verification
The properties assume that `bank_active` and `col_busy` are ordinary stable levels, sampled at the same edge as the command. They also assume that reset is held for at least one edge, so that the previous-level register starts high. The stimulus changes every input only half a cycle away from the active edge and restores legal sequencing after each deliberate violation. A deliberately dropped clock enable is followed first by the illegal low-to-high edge it implies, then by a legal edge. The relock check never places a violation on the final counting edge, so the exact exit cycle of R7 stays well defined.

// File: rtl/ddr_pwr_pkg.sv
package ddr_pwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ACTIVE = 3'd1,
    ST_PPD    = 3'd2,
    ST_APD    = 3'd3,
    ST_SREF   = 3'd4,
    ST_SRX    = 3'd5
  } pstate_e;

  typedef enum logic [2:0] {
    CMD_DESEL = 3'd0,
    CMD_NOP   = 3'd1,
    CMD_AREF  = 3'd2,
    CMD_READ  = 3'd3,
    CMD_OTHER = 3'd4
  } cmd_e;

  function automatic logic is_quiet(input cmd_e c);
    return (c == CMD_DESEL) || (c == CMD_NOP);
  endfunction

  function automatic logic is_running(input pstate_e s);
    return (s == ST_IDLE) || (s == ST_ACTIVE);
  endfunction

  function automatic logic is_low_power(input pstate_e s);
    return (s == ST_PPD) || (s == ST_APD) || (s == ST_SREF);
  endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_pwr_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  logic [2:0] strobes;
  assign strobes = {ras_n, cas_n, we_n};

  // R2: strobe patterns below are only meaningful with chip select low
  always_comb begin
    if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      case (strobes)
        3'b111:  cmd = CMD_NOP;
        3'b001:  cmd = CMD_AREF;
        3'b101:  cmd = CMD_READ;
        default: cmd = CMD_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/ddr_dll_wait.sv
module ddr_dll_wait #(
  parameter int CYCLES = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy,
  output logic last
);

  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= LOAD_VAL;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q <= CW'(1));

  // R7: a fresh load always leaves the full window outstanding
  assert_load_full_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == LOAD_VAL));

endmodule

// File: rtl/ddr_pwr_fsm.sv
module ddr_pwr_fsm
  import ddr_pwr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cke,
  input  cmd_e    cmd,
  input  logic    col_busy,
  input  logic    bank_active,
  input  logic    wait_last,
  output pstate_e state_q,
  output logic    illegal_q,
  output logic    srx_load
);

  logic    cke_prev_q;
  pstate_e nxt;
  logic    bad;
  logic    quiet;
  logic    running;
  logic    low_pwr;
  pstate_e run_state;

  assign quiet     = is_quiet(cmd);
  assign running   = is_running(state_q);
  assign low_pwr   = is_low_power(state_q);
  assign run_state = bank_active ? ST_ACTIVE : ST_IDLE;

  always_comb begin
    nxt      = state_q;
    bad      = 1'b0;
    srx_load = 1'b0;
    case ({cke_prev_q, cke})
      2'b00: begin
        // R5: held low, commands ignored
        if (!low_pwr) bad = 1'b1;
      end
      2'b01: begin
        // R6: exit on a quiet command only
        if (low_pwr && quiet) begin
          if (state_q == ST_SREF) begin
            nxt      = ST_SRX;
            srx_load = 1'b1;
          end else begin
            nxt = run_state;
          end
        end else begin
          bad = 1'b1;
        end
      end
      2'b10: begin
        // R3 / R4 / R9: entry only from a running state, no burst in flight
        if (running && !col_busy && quiet) begin
          nxt = bank_active ? ST_APD : ST_PPD;
        end else if (running && !col_busy && (cmd == CMD_AREF) && !bank_active) begin
          nxt = ST_SREF;
        end else begin
          bad = 1'b1;
        end
      end
      default: begin
        // R2 / R7 / R8
        if (running) begin
          nxt = run_state;
        end else if ((state_q == ST_SRX) && quiet) begin
          if (wait_last) nxt = ST_IDLE;
        end else begin
          bad = 1'b1;
        end
      end
    endcase
    if (bad) nxt = state_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_prev_q <= 1'b1;
      state_q    <= ST_IDLE;
      illegal_q  <= 1'b0;
    end else begin
      cke_prev_q <= cke;
      state_q    <= nxt;
      illegal_q  <= bad;
    end
  end

  assert_sref_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (running && cke_prev_q && !cke && (cmd == CMD_AREF) && !bank_active && !col_busy)
      |=> (state_q == ST_SREF));

  assert_lp_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (low_pwr && !cke_prev_q && !cke) |=> ($stable(state_q) && !illegal_q));

  assert_busy_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (cke_prev_q && !cke && col_busy) |=> (illegal_q && $stable(state_q)));

  assert_wait_cmd_R8: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_SRX) && !quiet) |=> ((state_q == ST_SRX) && illegal_q));

endmodule

// File: rtl/ddr_pwr_tracker.sv
module ddr_pwr_tracker
  import ddr_pwr_pkg::*;
#(
  parameter int DLL_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       col_busy,
  input  logic       bank_active,
  output logic [2:0] state_o,
  output logic       illegal_o,
  output logic       read_ok_o
);

  cmd_e    cmd;
  pstate_e state;
  logic    illegal;
  logic    srx_load;
  logic    wait_busy;
  logic    wait_last;

  ddr_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  ddr_dll_wait #(.CYCLES(DLL_CYCLES)) u_wait (
    .clk  (clk),
    .rst  (rst),
    .load (srx_load),
    .busy (wait_busy),
    .last (wait_last)
  );

  ddr_pwr_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .cke         (cke),
    .cmd         (cmd),
    .col_busy    (col_busy),
    .bank_active (bank_active),
    .wait_last   (wait_last),
    .state_q     (state),
    .illegal_q   (illegal),
    .srx_load    (srx_load)
  );

  assign state_o   = state;
  assign illegal_o = illegal;
  assign read_ok_o = is_running(state) && !wait_busy;

  // R7: the relock counter only runs while the tracker sits in the wait state
  assert_wait_in_srx_R7: assert property (@(posedge clk) disable iff (rst)
    wait_busy |-> (state == ST_SRX));

endmodule

// File: tb/ddr_pwr_tracker_tb_top.sv
module ddr_pwr_tracker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WAIT_CYC   = 200;

  localparam logic [3:0] C_NOP  = 4'b0111;
  localparam logic [3:0] C_DES  = 4'b1111;
  localparam logic [3:0] C_AREF = 4'b0001;
  localparam logic [3:0] C_READ = 4'b0101;
  localparam logic [3:0] C_ACT  = 4'b0011;

  typedef struct {
    logic [2:0] st;
    logic       ill;
    logic       rok;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic col_busy = 1'b0;
  logic bank_active = 1'b0;
  logic [2:0] state_o;
  logic illegal_o, read_ok_o;

  exp_t q[$];
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_pwr_tracker #(.DLL_CYCLES(WAIT_CYC)) dut_i (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .col_busy(col_busy),
    .bank_active(bank_active), .state_o(state_o),
    .illegal_o(illegal_o), .read_ok_o(read_ok_o)
  );

  task automatic step(input logic k, input logic [3:0] c, input logic busy,
                      input logic bank, input logic [2:0] es, input logic ei,
                      input logic er, input string tag);
    exp_t e;
    @(negedge clk);
    cke = k;
    {cs_n, ras_n, cas_n, we_n} = c;
    col_busy = busy;
    bank_active = bank;
    e.st = es; e.ill = ei; e.rok = er; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (state_o !== e.st || illegal_o !== e.ill || read_ok_o !== e.rok) begin
          bad++;
          $display("FAIL %s: got st=%0d ill=%0b rok=%0b exp st=%0d ill=%0b rok=%0b",
                   e.tag, state_o, illegal_o, read_ok_o, e.st, e.ill, e.rok);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    bad++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (state_o !== 3'd0 || illegal_o !== 1'b0 || read_ok_o !== 1'b1) begin
      bad++;
      $display("FAIL R1: got st=%0d ill=%0b rok=%0b exp st=0 ill=0 rok=1",
               state_o, illegal_o, read_ok_o);
    end
    rst = 1'b0;

    // R1 after release, R2 running states
    step(1, C_NOP,  0, 0, 3'd0, 0, 1, "R1");
    step(1, C_ACT,  0, 1, 3'd1, 0, 1, "R2");
    step(1, C_READ, 0, 1, 3'd1, 0, 1, "R2");
    // R3 active power-down, R5 hold, R6 exit
    step(0, C_NOP,  0, 1, 3'd3, 0, 0, "R3");
    step(0, C_AREF, 0, 1, 3'd3, 0, 0, "R5");
    step(0, C_ACT,  0, 0, 3'd3, 0, 0, "R5");
    step(1, C_DES,  0, 1, 3'd1, 0, 1, "R6");
    step(1, C_NOP,  0, 0, 3'd0, 0, 1, "R2");
    step(0, C_DES,  0, 0, 3'd2, 0, 0, "R3");
    step(1, C_NOP,  0, 0, 3'd0, 0, 1, "R6");
    // R9 drop during burst, then R10 / R11 recovery
    step(0, C_NOP,  1, 0, 3'd0, 1, 1, "R9");
    step(1, C_NOP,  0, 0, 3'd0, 1, 1, "R10");
    step(1, C_NOP,  0, 0, 3'd0, 0, 1, "R11");
    // R10 auto refresh with a bank open
    step(0, C_AREF, 0, 1, 3'd0, 1, 1, "R10");
    step(1, C_NOP,  0, 0, 3'd0, 1, 1, "R10");
    step(1, C_NOP,  0, 0, 3'd0, 0, 1, "R11");
    // R4 self refresh, R5 hold, R10 bad exits, R6 exit to wait
    step(0, C_AREF, 0, 0, 3'd4, 0, 0, "R4");
    step(0, C_NOP,  0, 0, 3'd4, 0, 0, "R5");
    step(1, C_AREF, 0, 0, 3'd4, 1, 0, "R10");
    step(0, C_NOP,  0, 0, 3'd4, 1, 0, "R10");
    step(1, C_NOP,  0, 0, 3'd5, 0, 0, "R6");
    // R8 read during wait, R7 wait length
    step(1, C_READ, 0, 0, 3'd5, 1, 0, "R8");
    for (int i = 2; i < WAIT_CYC; i++) begin
      step(1, (i % 2 == 0) ? C_NOP : C_DES, 0, 0, 3'd5, 0, 0, "R7");
    end
    step(1, C_NOP,  0, 0, 3'd0, 0, 1, "R7");
    step(1, C_READ, 0, 0, 3'd0, 0, 1, "R7");

    repeat (3) @(posedge clk);
    #2;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule